// File: doc/BRIEF.md
# Link Bring-Up Retry Sequencer

This block brings up a serial link whose PHY lane does not always train on the first try. For each attempt it first releases the lane's receive override, then fires a hard reset on an external link-reset engine and records whether the link came online. After that it waits for the lane to leave half-rate operation. It then forces the receive DPLL into a fixed mode with a reset pulse, waits a programmable settling time, and optionally forces a transmit attenuation value. All PHY register traffic goes through an indirect PHY access master using a request/acknowledge handshake.

After each attempt the sequencer reads the link status. It stops in four cases: the status read reports an error, the two low status bits show that no device is attached, the link is online, or the retry budget is spent. A one-cycle done pulse ends the run. The online and error results stay valid until the next start. The reset timing values that the link-reset engine needs come out as constant configuration ports.

Top module: `link_bringup_seq`

## Requirements
- R1: After start, the first PHY command is a read of the lane's RX input status at address 0x2002 + lane*0x100. It is followed by a write of that value with bit 14 cleared to the RX override register at 0x2005 + lane*0x100.
- R2: The link reset is started by a single-cycle pulse on lrst_start_o. The pulse comes only after the override-release write has been acknowledged. The online result is captured from lrst_online_i in the cycle that lrst_done_i is high.
- R3: After the reset, the RX input status is read again as long as bit 0 (half rate) is set. At most POLL_MAX extra reads are made, so there are no more than POLL_MAX+1 reads in total (1001 by default). The last value read is the base for R4.
- R4: Five writes go to the RX override register, with v as the base value. The sequence is a=v with bit 14 cleared; then a with bit 14 set; then that with bits 10:8 replaced by 3; then that with bit 11 set; then the same with bit 11 cleared.
- R5: After the fifth RX write is acknowledged, the block stays idle on all command outputs for settle_cycles_i+1 cycles. Its next command follows in the cycle after that.
- R6: When tx_atten_i bit 3 is set, no transmit register is accessed.
- R7: Otherwise the block reads the TX input status at 0x2001 + lane*0x100 and makes three writes to 0x2004 + lane*0x100. The values are the status with bit 15 cleared; then with bit 15 set; then that ORed with tx_atten_i[2:0] placed at bits 12:10.
- R8: Each attempt ends with a status read. If stat_lnk_i (the two low link status bits) is 00, the run ends at once whatever the online result.
- R9: If the link is not online and stat_lnk_i is non-zero, the attempt is repeated up to RETRY_MAX extra times (101 attempts by default). online_o reports the result of the last attempt.
- R10: If stat_err_i is high with the status acknowledge, the run ends with err_o high. This takes precedence over the no-device case.
- R11: A PHY request holds its address, direction and data stable until acknowledged. At most one of phy_req_o, stat_req_o and lrst_start_o is high at a time.
- R12: lrst_interval_o, lrst_duration_o and lrst_timeout_o always equal T_INTERVAL, T_DURATION and T_TIMEOUT (defaults 5, 100 and 500).
- R13: After reset all request outputs, done_o, online_o and err_o are low. done_o is a single-cycle pulse at the end of each run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a bring-up run (taken while idle) |
| lane_i | input | LANE_W | Lane index inside the PHY |
| tx_atten_i | input | 4 | Transmit attenuation; bit 3 disables the TX override |
| settle_cycles_i | input | CW | Settling wait after the DPLL reset pulse, in cycles |
| phy_req_o | output | 1 | PHY register command request |
| phy_we_o | output | 1 | 1 = write, 0 = read |
| phy_addr_o | output | AW | PHY register address |
| phy_wdata_o | output | DW | PHY write data |
| phy_ack_i | input | 1 | PHY command completed |
| phy_rdata_i | input | DW | PHY read data, valid with acknowledge |
| lrst_start_o | output | 1 | Start a link hard reset |
| lrst_done_i | input | 1 | Link hard reset finished |
| lrst_online_i | input | 1 | Link online result, valid with done |
| lrst_interval_o | output | TW | Reset timing: interval |
| lrst_duration_o | output | TW | Reset timing: duration |
| lrst_timeout_o | output | TW | Reset timing: timeout |
| stat_req_o | output | 1 | Link status read request |
| stat_ack_i | input | 1 | Link status read completed |
| stat_err_i | input | 1 | Link status read failed |
| stat_lnk_i | input | 2 | Low link status bits, valid with acknowledge |
| done_o | output | 1 | One-cycle end-of-run pulse |
| online_o | output | 1 | Link online at the last attempt |
| err_o | output | 1 | Run ended on a failed status read |

## Verification
In a single status acknowledge, a failed read can coincide with the no-device code, and the no-device code can coincide with an online result. The bench drives both pairs on the same acknowledge cycle. It then judges which exit was taken from err_o, online_o and the number of reset pulses counted. A second overlap is the half-rate poll limit meeting a still-set half-rate bit. There the bench keeps bit 0 set beyond the limit and checks that the override writes start from the last polled value.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
   typedef enum logic [3:0] {
      S_IDLE, S_DIS_RD, S_DIS_WR, S_LRST, S_LWAIT, S_HR_RD,
      S_RX_WR, S_SETTLE, S_TX_RD, S_TX_WR, S_ST_RD, S_DONE
   } lbs_state_e;

   // lane register offsets and stride
   localparam logic [15:0] TX_STS_OFS  = 16'h2001;
   localparam logic [15:0] RX_STS_OFS  = 16'h2002;
   localparam logic [15:0] TX_OVR_OFS  = 16'h2004;
   localparam logic [15:0] RX_OVR_OFS  = 16'h2005;
   localparam int          LANE_SHIFT  = 8;

   // bit positions inside the override words
   localparam int HALF_RATE_BIT = 0;
   localparam int DPLL_MODE_LSB = 8;
   localparam int DPLL_MODE_W   = 3;
   localparam int DPLL_RST_BIT  = 11;
   localparam int ATTEN_LSB     = 10;
   localparam int ATTEN_FLD_W   = 3;
   localparam int RX_FORCE_BIT  = 14;
   localparam int TX_FORCE_BIT  = 15;
   localparam int ATTEN_SKIP    = 3;

   localparam int RX_STEPS = 5;
   localparam int TX_STEPS = 3;
endpackage

// File: rtl/lbs_timer.sv
module lbs_timer #(
   parameter int CW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/lbs_ovr_data.sv
module lbs_ovr_data
   import lbs_pkg::*;
#(
   parameter int                    DW        = 16,
   parameter logic [DPLL_MODE_W-1:0] DPLL_MODE = 3'd3
) (
   input  logic [DW-1:0] base,
   input  logic [2:0]    step,
   input  logic          tx_sel,
   input  logic [2:0]    atten,
   output logic [DW-1:0] wdata
);
   localparam logic [DW-1:0] RX_FORCE = DW'(1) << RX_FORCE_BIT;
   localparam logic [DW-1:0] TX_FORCE = DW'(1) << TX_FORCE_BIT;
   localparam logic [DW-1:0] DPLL_RST = DW'(1) << DPLL_RST_BIT;
   localparam logic [DW-1:0] MODE_MSK = DW'((1 << DPLL_MODE_W) - 1) << DPLL_MODE_LSB;

   logic [DW-1:0] rx_rel, rx_frc, rx_mode, tx_rel, tx_frc, tx_att;

   always_comb begin
      rx_rel  = base & ~RX_FORCE;
      rx_frc  = rx_rel | RX_FORCE;
      rx_mode = (rx_frc & ~MODE_MSK) | (DW'(DPLL_MODE) << DPLL_MODE_LSB);
      tx_rel  = base & ~TX_FORCE;
      tx_frc  = tx_rel | TX_FORCE;
      tx_att  = tx_frc | (DW'(atten) << ATTEN_LSB);
      if (tx_sel) begin
         case (step)
            3'd0:    wdata = tx_rel;
            3'd1:    wdata = tx_frc;
            default: wdata = tx_att;
         endcase
      end else begin
         case (step)
            3'd0:    wdata = rx_rel;
            3'd1:    wdata = rx_frc;
            3'd2:    wdata = rx_mode;
            3'd3:    wdata = rx_mode | DPLL_RST;
            default: wdata = rx_mode & ~DPLL_RST;
         endcase
      end
   end
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
   import lbs_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 16,
   parameter int LANE_W     = 2,
   parameter int CW         = 24,
   parameter int TW         = 32,
   parameter int POLL_MAX   = 1000,
   parameter int RETRY_MAX  = 100,
   parameter int T_INTERVAL = 5,
   parameter int T_DURATION = 100,
   parameter int T_TIMEOUT  = 500,
   parameter logic [2:0] DPLL_MODE = 3'd3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [LANE_W-1:0] lane_i,
   input  logic [3:0]        tx_atten_i,
   input  logic [CW-1:0]     settle_cycles_i,
   output logic              phy_req_o,
   output logic              phy_we_o,
   output logic [AW-1:0]     phy_addr_o,
   output logic [DW-1:0]     phy_wdata_o,
   input  logic              phy_ack_i,
   input  logic [DW-1:0]     phy_rdata_i,
   output logic              lrst_start_o,
   input  logic              lrst_done_i,
   input  logic              lrst_online_i,
   output logic [TW-1:0]     lrst_interval_o,
   output logic [TW-1:0]     lrst_duration_o,
   output logic [TW-1:0]     lrst_timeout_o,
   output logic              stat_req_o,
   input  logic              stat_ack_i,
   input  logic              stat_err_i,
   input  logic [1:0]        stat_lnk_i,
   output logic              done_o,
   output logic              online_o,
   output logic              err_o
);
   localparam int PW = $clog2(POLL_MAX + 1);
   localparam int RW = $clog2(RETRY_MAX + 1);

   generate
      if (AW < 16)            begin : g_bad_aw    $error("AW must be at least 16");        end
      if (DW < 16)            begin : g_bad_dw    $error("DW must be at least 16");        end
      if (LANE_W < 1 || LANE_W > AW - 14)
                              begin : g_bad_lane  $error("LANE_W out of range");           end
      if (POLL_MAX < 1)       begin : g_bad_poll  $error("POLL_MAX must be positive");     end
      if (RETRY_MAX < 0)      begin : g_bad_retry $error("RETRY_MAX must not be negative"); end
   endgenerate

   lbs_state_e        state;
   logic [2:0]        step_q;
   logic [PW-1:0]     poll_q;
   logic [RW:0]       retry_q;
   logic [DW-1:0]     base_q;
   logic [LANE_W-1:0] lane_q;
   logic [3:0]        atten_q;
   logic              online_q, err_q, tmr_zero, tmr_load;
   logic [AW-1:0]     lane_ofs;

   assign tmr_load = (state == S_RX_WR) && phy_ack_i && (step_q == 3'(RX_STEPS - 1));

   lbs_timer #(.CW(CW)) u_settle (
      .clk(clk), .rst_n(rst_n), .load(tmr_load),
      .load_val(settle_cycles_i), .zero(tmr_zero)
   );

   lbs_ovr_data #(.DW(DW), .DPLL_MODE(DPLL_MODE)) u_data (
      .base(base_q),
      .step((state == S_DIS_WR) ? 3'd0 : step_q),
      .tx_sel(state == S_TX_WR),
      .atten(atten_q[2:0]),
      .wdata(phy_wdata_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         step_q   <= '0;
         poll_q   <= '0;
         retry_q  <= '0;
         base_q   <= '0;
         lane_q   <= '0;
         atten_q  <= '0;
         online_q <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         case (state)
            S_IDLE: if (start_i) begin
               state    <= S_DIS_RD;
               retry_q  <= '0;
               online_q <= 1'b0;
               err_q    <= 1'b0;
               lane_q   <= lane_i;
               atten_q  <= tx_atten_i;
            end
            S_DIS_RD: if (phy_ack_i) begin
               base_q <= phy_rdata_i;
               state  <= S_DIS_WR;
            end
            S_DIS_WR: if (phy_ack_i) state <= S_LRST;
            S_LRST:   state <= S_LWAIT;
            S_LWAIT: if (lrst_done_i) begin
               online_q <= lrst_online_i;
               poll_q   <= '0;
               state    <= S_HR_RD;
            end
            S_HR_RD: if (phy_ack_i) begin
               base_q <= phy_rdata_i;
               if (phy_rdata_i[HALF_RATE_BIT] && (poll_q < PW'(POLL_MAX))) begin
                  poll_q <= poll_q + 1'b1;
               end else begin
                  step_q <= '0;
                  state  <= S_RX_WR;
               end
            end
            S_RX_WR: if (phy_ack_i) begin
               if (step_q == 3'(RX_STEPS - 1)) state <= S_SETTLE;
               else                            step_q <= step_q + 1'b1;
            end
            S_SETTLE: if (tmr_zero) state <= atten_q[ATTEN_SKIP] ? S_ST_RD : S_TX_RD;
            S_TX_RD: if (phy_ack_i) begin
               base_q <= phy_rdata_i;
               step_q <= '0;
               state  <= S_TX_WR;
            end
            S_TX_WR: if (phy_ack_i) begin
               if (step_q == 3'(TX_STEPS - 1)) state <= S_ST_RD;
               else                            step_q <= step_q + 1'b1;
            end
            S_ST_RD: if (stat_ack_i) begin
               if (stat_err_i) begin
                  err_q <= 1'b1;
                  state <= S_DONE;
               end else if (stat_lnk_i == 2'b00) begin
                  state <= S_DONE;
               end else if (!online_q && (retry_q < (RW+1)'(RETRY_MAX))) begin
                  retry_q <= retry_q + 1'b1;
                  state   <= S_DIS_RD;
               end else begin
                  state <= S_DONE;
               end
            end
            S_DONE:  state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign lane_ofs = AW'(lane_q) << LANE_SHIFT;

   always_comb begin
      phy_req_o  = 1'b1;
      phy_we_o   = 1'b0;
      phy_addr_o = '0;
      case (state)
         S_DIS_RD, S_HR_RD: phy_addr_o = AW'(RX_STS_OFS) + lane_ofs;
         S_DIS_WR, S_RX_WR: begin phy_we_o = 1'b1; phy_addr_o = AW'(RX_OVR_OFS) + lane_ofs; end
         S_TX_RD:           phy_addr_o = AW'(TX_STS_OFS) + lane_ofs;
         S_TX_WR:           begin phy_we_o = 1'b1; phy_addr_o = AW'(TX_OVR_OFS) + lane_ofs; end
         default:           phy_req_o = 1'b0;
      endcase
   end

   assign lrst_start_o    = (state == S_LRST);
   assign stat_req_o      = (state == S_ST_RD);
   assign done_o          = (state == S_DONE);
   assign online_o        = online_q;
   assign err_o           = err_q;
   assign lrst_interval_o = TW'(T_INTERVAL);
   assign lrst_duration_o = TW'(T_DURATION);
   assign lrst_timeout_o  = TW'(T_TIMEOUT);
endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
   parameter int AW        = 16,
   parameter int DW        = 16,
   parameter int RETRY_MAX = 100
) (
   input logic          clk,
   input logic          rst_n,
   input logic          phy_req,
   input logic          phy_we,
   input logic [AW-1:0] phy_addr,
   input logic [DW-1:0] phy_wdata,
   input logic          phy_ack,
   input logic          lrst_start,
   input logic          stat_req,
   input logic          stat_ack,
   input logic          done,
   input logic          err
);
   localparam int CNTW = $clog2(RETRY_MAX + 2) + 1;
   logic [CNTW-1:0] att_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          att_cnt <= '0;
      else if (done)       att_cnt <= '0;
      else if (lrst_start) att_cnt <= att_cnt + 1'b1;
   end

   AST_PHY_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      phy_req && !phy_ack |=> phy_req && $stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata)); // R11
   AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({phy_req, stat_req, lrst_start})); // R11
   AST_LRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      lrst_start |=> !lrst_start); // R2
   AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      stat_req && !stat_ack |=> stat_req); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R13
   AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> done); // R10
   AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      att_cnt <= CNTW'(RETRY_MAX + 1)); // R9
endmodule

bind link_bringup_seq lbs_checker #(.AW(AW), .DW(DW), .RETRY_MAX(RETRY_MAX)) u_lbs_chk (
   .clk(clk), .rst_n(rst_n), .phy_req(phy_req_o), .phy_we(phy_we_o),
   .phy_addr(phy_addr_o), .phy_wdata(phy_wdata_o), .phy_ack(phy_ack_i),
   .lrst_start(lrst_start_o), .stat_req(stat_req_o), .stat_ack(stat_ack_i),
   .done(done_o), .err(err_o)
);

// File: tb/sim_link_bringup_seq.sv
`timescale 1ns/1ps
module sim_link_bringup_seq;
   localparam int POLL_MAX  = 1000;
   localparam int RETRY_MAX = 100;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n = 1'b0, start_i = 1'b0;
   logic [1:0]  lane_i = '0;
   logic [3:0]  tx_atten_i = '0;
   logic [23:0] settle_cycles_i = '0;
   logic        phy_req_o, phy_we_o, phy_ack_i = 1'b0;
   logic [15:0] phy_addr_o, phy_wdata_o, phy_rdata_i = '0;
   logic        lrst_start_o, lrst_done_i = 1'b0, lrst_online_i = 1'b0;
   logic [31:0] lrst_interval_o, lrst_duration_o, lrst_timeout_o;
   logic        stat_req_o, stat_ack_i = 1'b0, stat_err_i = 1'b0;
   logic [1:0]  stat_lnk_i = '0;
   logic        done_o, online_o, err_o;

   link_bringup_seq u0 (.*);

   int checks = 0, errors = 0, pcyc = 0;
   always @(posedge clk) pcyc <= pcyc + 1;

   // scoreboard of expected PHY commands
   bit          q_we[$];
   logic [15:0] q_addr[$], q_wdata[$], q_rdata[$];
   int          q_kind[$];
   string       q_tag[$];

   int   c_online_from = 1, lrst_seen = 0, last_rxw = 0;
   logic [1:0] c_stat = 2'b11;
   bit   c_err = 1'b0, gap_en = 1'b0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push(input bit we, input logic [15:0] a, input logic [15:0] d,
                       input logic [15:0] r, input int kind, input string tag);
      q_we.push_back(we); q_addr.push_back(a); q_wdata.push_back(d);
      q_rdata.push_back(r); q_kind.push_back(kind); q_tag.push_back(tag);
   endtask

   // monitor / responder for the PHY access master
   initial forever begin
      @(negedge clk);
      if (phy_req_o) begin
         logic [15:0] rd;
         rd = '0;
         if (q_we.size() == 0) begin
            check(1'b0, "R1 unexpected PHY command", {phy_we_o, 15'd0, phy_addr_o}, 32'd0);
         end else begin
            bit we; logic [15:0] a, d; int k; string t; bit ok;
            we = q_we.pop_front(); a = q_addr.pop_front(); d = q_wdata.pop_front();
            rd = q_rdata.pop_front(); k = q_kind.pop_front(); t = q_tag.pop_front();
            ok = (phy_we_o == we) && (phy_addr_o == a) && (!we || phy_wdata_o == d);
            check(ok, t, {phy_we_o, phy_addr_o, phy_wdata_o[14:0]}, {we, a, d[14:0]});
            if (we && phy_wdata_o[15] != d[15])
               check(1'b0, t, {16'd0, phy_wdata_o}, {16'd0, d});
            if (k == 1) last_rxw = pcyc;
            if (k == 2 && gap_en)
               check(pcyc - last_rxw == int'(settle_cycles_i) + 3, "R5 settle gap",
                     pcyc - last_rxw, int'(settle_cycles_i) + 3);
         end
         @(negedge clk); phy_ack_i = 1'b1; phy_rdata_i = rd;
         @(negedge clk); phy_ack_i = 1'b0;
      end
   end

   // link reset engine model
   initial forever begin
      @(negedge clk);
      if (lrst_start_o) begin
         lrst_seen++;
         @(negedge clk); lrst_done_i = 1'b1; lrst_online_i = (lrst_seen >= c_online_from);
         @(negedge clk); lrst_done_i = 1'b0; lrst_online_i = 1'b0;
      end
   end

   // status reader model
   initial forever begin
      @(negedge clk);
      if (stat_req_o) begin
         @(negedge clk); stat_ack_i = 1'b1; stat_lnk_i = c_stat; stat_err_i = c_err;
         @(negedge clk); stat_ack_i = 1'b0; stat_lnk_i = '0; stat_err_i = 1'b0;
      end
   end

   task automatic run_case(input string name, input logic [1:0] lane, input logic [3:0] att,
                           input int settle, input int onl_from, input logic [1:0] st,
                           input bit serr, input int polls, input bit gap);
      int   attempts, n_set;
      bit   exp_on;
      logic [15:0] ofs, rxd, v, r0, r1, r2, t, t0;
      ofs = 16'(lane) << 8;
      c_online_from = onl_from; c_stat = st; c_err = serr; lrst_seen = 0; gap_en = gap;
      attempts = 1;
      forever begin
         exp_on = (attempts >= onl_from);
         if (serr || st == 2'b00 || exp_on || attempts == RETRY_MAX + 1) break;
         attempts++;
      end
      for (int a = 1; a <= attempts; a++) begin
         rxd = 16'h4A30 + 16'(a);
         push(0, 16'h2002 + ofs, '0, rxd, 0, "R1 status read");
         push(1, 16'h2005 + ofs, rxd & ~16'h4000, '0, 0, "R1 override release");
         v = 16'hCF62 ^ 16'(a << 4);
         n_set = (polls > POLL_MAX) ? POLL_MAX + 1 : polls;
         for (int p = 0; p < n_set; p++) push(0, 16'h2002 + ofs, '0, v | 16'h1, 0, "R3 half-rate poll");
         if (polls <= POLL_MAX) push(0, 16'h2002 + ofs, '0, v, 0, "R3 final poll");
         else v = v | 16'h1;
         r0 = v & ~16'h4000; r1 = r0 | 16'h4000; r2 = (r1 & ~16'h0700) | 16'h0300;
         push(1, 16'h2005 + ofs, r0, '0, 0, "R4 write 1");
         push(1, 16'h2005 + ofs, r1, '0, 0, "R4 write 2");
         push(1, 16'h2005 + ofs, r2, '0, 0, "R4 write 3");
         push(1, 16'h2005 + ofs, r2 | 16'h0800, '0, 0, "R4 write 4");
         push(1, 16'h2005 + ofs, r2 & ~16'h0800, '0, 1, "R4 write 5");
         if (!att[3]) begin
            t = 16'hF3C4 ^ 16'(a);
            t0 = t & ~16'h8000;
            push(0, 16'h2001 + ofs, '0, t, 2, "R7 tx status read");
            push(1, 16'h2004 + ofs, t0, '0, 0, "R7 tx write 1");
            push(1, 16'h2004 + ofs, t0 | 16'h8000, '0, 0, "R7 tx write 2");
            push(1, 16'h2004 + ofs, t0 | 16'h8000 | (16'(att[2:0]) << 10), '0, 0, "R7 tx write 3");
         end
      end
      @(negedge clk);
      lane_i = lane; tx_atten_i = att; settle_cycles_i = 24'(settle); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      while (!done_o) @(negedge clk);
      $display("case %s: %0d attempts", name, lrst_seen);
      check(online_o == exp_on, {"R9 online result ", name}, online_o, exp_on);
      check(err_o == serr, {"R10 error flag ", name}, err_o, serr);
      check(lrst_seen == attempts, {"R8 attempt count ", name}, lrst_seen, attempts);
      check(q_we.size() == 0, {"R6 commands left ", name}, q_we.size(), 0);
      @(negedge clk);
      check(done_o == 1'b0, {"R13 done pulse ", name}, done_o, 0);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (199000) @(posedge clk);
      checks++; errors++;
      $display("FAIL R13 watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check({phy_req_o, stat_req_o, lrst_start_o, done_o, online_o, err_o} == 6'b0,
            "R13 reset state", {phy_req_o, stat_req_o, lrst_start_o, done_o, online_o, err_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(lrst_interval_o == 32'd5,   "R12 interval",  lrst_interval_o, 5);
      check(lrst_duration_o == 32'd100, "R12 duration",  lrst_duration_o, 100);
      check(lrst_timeout_o  == 32'd500, "R12 timeout",   lrst_timeout_o, 500);
      run_case("online_first", 2'd0, 4'h5, 4, 1, 2'b11, 1'b0, 0,    1'b1); // R2 R5 R7
      run_case("skip_tx_retry", 2'd3, 4'hA, 2, 3, 2'b01, 1'b0, 2,   1'b0); // R3 R6 R9
      run_case("no_device",    2'd1, 4'h2, 1, 9999, 2'b00, 1'b0, 0, 1'b0); // R8
      run_case("err_and_nodev", 2'd2, 4'h1, 0, 1, 2'b00, 1'b1, 0,   1'b0); // R10
      run_case("retry_exhaust", 2'd2, 4'h8, 0, 9999, 2'b10, 1'b0, 0, 1'b0); // R9
      run_case("poll_limit",   2'd1, 4'h7, 3, 1, 2'b11, 1'b0, 2000, 1'b0); // R3
      run_case("zero_settle",  2'd0, 4'h0, 0, 1, 2'b01, 1'b0, 1000, 1'b1); // R5
      run_case("nodev_online", 2'd3, 4'h3, 1, 1, 2'b00, 1'b0, 0,    1'b0); // R8
      finish_run();
   end
endmodule